// File: doc/BRIEF.md
# Quad-channel DAC register controller

This block holds the digital state behind a four-channel converter. An upstream serial receiver hands it one checked command frame per cycle: an opcode, a channel address and a 16-bit data word. Each channel keeps two codes. The staged (input) code is what the frames write. The live (output) code is what drives the converter. Staged codes move to live codes in one of three ways: as part of the frame itself, on a falling edge of an active-low load strobe, or for chosen channels at once through a software mask that makes a channel act as if the strobe were held low.

An active-low clear pin forces every staged and live code to a software-chosen code: zero, midscale or full scale. Each channel can also be set to one of three power-down termination modes, and its codes are kept while it is powered down. A hardware reset and a software reset command return everything to zero scale or to midscale, as chosen by a strap input. The load and clear pins are asynchronous. They go through two-flop synchronizers, and their falling edges are detected in the system clock domain.

Top module: `quad_dac_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every staged and live code loads 0x0000 if `por_mid` is 0, or 0x8000 if it is 1. All power modes go to 00, the override mask goes to 0 and the clear selector goes to 00. Pin edges seen during reset have no effect.
- R2: For opcodes 0000 to 0011, `frame_addr` 0, 1, 2 and 3 select channels A, B, C and D, and 4'hF selects all four. Any other address makes these opcodes do nothing.
- R3: Opcode 0000 writes the staged code of the selected channels. The live code takes the same value at that edge if the synchronized `ldac_n` is low or the channel's override bit is 1. Otherwise the live code holds.
- R4: A falling edge of `ldac_n` copies every staged code to its live code. A pin that falls between two clock edges shows up on the outputs after the third rising edge that follows.
- R5: Opcode 0001 copies staged to live for the selected channels. Opcode 0010 writes the selected staged codes and then copies all four channels. Opcode 0011 writes both codes of the selected channels. All three act regardless of the level of `ldac_n`.
- R6: Opcode 0110 loads the override mask from data bits 3..0, with bit 0 for channel A and bit 3 for channel D.
- R7: Opcode 0101 sets the clear selector from data bits 1:0: 00 selects 0x0000, 01 selects 0x8000 and 10 selects 0xFFFF. The value 11 leaves the selector unchanged.
- R8: A synchronized falling edge of `clr_n` loads the selected clear code into all staged and live codes. A frame presented in that same cycle is dropped.
- R9: While the synchronized `clr_n` is low, falling edges of `ldac_n` do nothing.
- R10: Opcode 0100 sets the power mode of each channel whose data bit (3..0 for D..A) is 1 to data bits 9:8. The modes are 00 normal, 01 1 kOhm to ground, 10 100 kOhm to ground and 11 high impedance. `pd_mode` carries channel A in bits 1:0. Live codes are unchanged.
- R11: Opcode 0111 has the same effect as R1, using the present `por_mid`.
- R12: Opcodes 1000 to 1111 change no output and no state.
- R13: When a frame and an `ldac_n` falling edge land in the same cycle, the frame's staged write happens first and the copy uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_valid | input | 1 | One-cycle strobe for a completed frame |
| frame_cmd | input | 4 | Frame opcode |
| frame_addr | input | 4 | Frame channel address |
| frame_data | input | 16 | Frame data word |
| ldac_n | input | 1 | Asynchronous active-low load strobe |
| clr_n | input | 1 | Asynchronous active-low clear |
| por_mid | input | 1 | Reset strap: 1 gives midscale, 0 gives zero scale |
| dac_code | output | 64 | Live codes, channel A in bits 15:0 and D in 63:48 |
| pd_mode | output | 8 | Power modes, two bits per channel, A in bits 1:0 |

## Verification
The bench places the corner cases on exact cycles.

- A clear edge and a frame arrive in the same cycle. A design that let the frame through would leave channel A at the frame value instead of the clear code.
- A load edge and a write arrive in the same cycle. A design that copied before writing would show the old staged value.
- A load pulse arrives while clear is held low, and the bench writes during clear. A design that honoured the pulse would release the new code early.
- Other cases cover unmapped addresses, reserved opcodes, clear selector 11, and whether the software reset clears the override mask. A leftover mask would make a later staged-only write appear on the output at once.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

  localparam logic [3:0] OP_WRITE     = 4'h0;
  localparam logic [3:0] OP_COPY      = 4'h1;
  localparam logic [3:0] OP_WRITE_ALL = 4'h2;
  localparam logic [3:0] OP_WRITE_UPD = 4'h3;
  localparam logic [3:0] OP_POWER     = 4'h4;
  localparam logic [3:0] OP_CLRSEL    = 4'h5;
  localparam logic [3:0] OP_OVERRIDE  = 4'h6;
  localparam logic [3:0] OP_RESET     = 4'h7;

  typedef struct packed {
    logic write;
    logic copy;
    logic write_all;
    logic write_upd;
    logic power;
    logic clrsel;
    logic override;
    logic reset;
  } op_t;

endpackage

// File: rtl/qdac_edge_sync.sv
module qdac_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic fall
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '1;
      prev_q <= 1'b1;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], pin};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign level = sh_q[STAGES-1];
  assign fall  = prev_q & ~sh_q[STAGES-1];
endmodule

// File: rtl/qdac_decode.sv
module qdac_decode
  import qdac_pkg::*;
#(
  parameter int CH     = 4,
  parameter int ADDR_W = 4
) (
  input  logic              accept,
  input  logic [3:0]        cmd,
  input  logic [ADDR_W-1:0] addr,
  output op_t               op,
  output logic [CH-1:0]     sel
);
  logic addr_ok;

  always_comb begin
    for (int i = 0; i < CH; i++) begin
      sel[i] = (addr == ADDR_W'(i)) || (addr == {ADDR_W{1'b1}});
    end
    addr_ok = |sel;
    op = '0;
    if (accept) begin
      case (cmd)
        OP_WRITE:     op.write     = addr_ok;
        OP_COPY:      op.copy      = addr_ok;
        OP_WRITE_ALL: op.write_all = addr_ok;
        OP_WRITE_UPD: op.write_upd = addr_ok;
        OP_POWER:     op.power     = 1'b1;
        OP_CLRSEL:    op.clrsel    = 1'b1;
        OP_OVERRIDE:  op.override  = 1'b1;
        OP_RESET:     op.reset     = 1'b1;
        default:      op = '0;
      endcase
    end
  end
endmodule

// File: rtl/qdac_channel.sv
module qdac_channel #(
  parameter int CODE_W = 16
) (
  input  logic              clk,
  input  logic              load_rst,
  input  logic [CODE_W-1:0] rst_val,
  input  logic              load_clr,
  input  logic [CODE_W-1:0] clr_val,
  input  logic              wr,
  input  logic [CODE_W-1:0] wr_val,
  input  logic              xfer,
  input  logic              pd_wr,
  input  logic [1:0]        pd_val,
  output logic [CODE_W-1:0] live,
  output logic [1:0]        pd
);
  logic [CODE_W-1:0] staged_q;

  always_ff @(posedge clk) begin
    if (load_rst) begin
      staged_q <= rst_val;
      live     <= rst_val;
    end else if (load_clr) begin
      staged_q <= clr_val;
      live     <= clr_val;
    end else begin
      if (wr)   staged_q <= wr_val;
      if (xfer) live     <= wr ? wr_val : staged_q;
    end
  end

  always_ff @(posedge clk) begin
    if (load_rst)   pd <= 2'b00;
    else if (pd_wr) pd <= pd_val;
  end
endmodule

// File: rtl/quad_dac_ctrl.sv
module quad_dac_ctrl
  import qdac_pkg::*;
#(
  parameter int CH          = 4,
  parameter int CODE_W      = 16,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_valid,
  input  logic [3:0]           frame_cmd,
  input  logic [ADDR_W-1:0]    frame_addr,
  input  logic [CODE_W-1:0]    frame_data,
  input  logic                 ldac_n,
  input  logic                 clr_n,
  input  logic                 por_mid,
  output logic [CH*CODE_W-1:0] dac_code,
  output logic [2*CH-1:0]      pd_mode
);
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

  function automatic logic [CODE_W-1:0] clear_code_of(input logic [1:0] s);
    case (s)
      2'b00:   return '0;
      2'b01:   return MID_CODE;
      default: return '1;
    endcase
  endfunction

  function automatic logic [CODE_W-1:0] reset_code_of(input logic mid);
    return mid ? MID_CODE : '0;
  endfunction

  // Synchronized pin events
  logic ldac_lvl, ldac_fall, clr_lvl, clr_fall;

  qdac_edge_sync #(.STAGES(SYNC_STAGES)) u_ldac_sync (
    .clk(clk), .rst_n(rst_n), .pin(ldac_n), .level(ldac_lvl), .fall(ldac_fall));
  qdac_edge_sync #(.STAGES(SYNC_STAGES)) u_clr_sync (
    .clk(clk), .rst_n(rst_n), .pin(clr_n), .level(clr_lvl), .fall(clr_fall));

  // Frame acceptance and decode
  logic          frame_ok;
  op_t           op;
  logic [CH-1:0] sel;

  assign frame_ok = frame_valid & ~clr_fall;

  qdac_decode #(.CH(CH), .ADDR_W(ADDR_W)) u_dec (
    .accept(frame_ok), .cmd(frame_cmd), .addr(frame_addr), .op(op), .sel(sel));

  // Control state
  logic              do_rst, ldac_fire;
  logic [1:0]        clr_sel_q;
  logic [CH-1:0]     ovr_q;
  logic [CODE_W-1:0] clear_code_val, reset_code_val;

  assign do_rst         = ~rst_n | op.reset;
  assign ldac_fire      = ldac_fall & clr_lvl;
  assign clear_code_val = clear_code_of(clr_sel_q);
  assign reset_code_val = reset_code_of(por_mid);

  always_ff @(posedge clk) begin
    if (do_rst) begin
      clr_sel_q <= 2'b00;
      ovr_q     <= '0;
    end else begin
      if (op.clrsel && frame_data[1:0] != 2'b11) clr_sel_q <= frame_data[1:0];
      if (op.override) ovr_q <= frame_data[CH-1:0];
    end
  end

  // Channels
  for (genvar i = 0; i < CH; i++) begin : g_ch
    logic wr_i, xfer_i;
    assign wr_i   = sel[i] & (op.write | op.write_all | op.write_upd);
    assign xfer_i = ldac_fire | op.write_all |
                    (sel[i] & (op.copy | op.write_upd | (op.write & (~ldac_lvl | ovr_q[i]))));

    qdac_channel #(.CODE_W(CODE_W)) u_ch (
      .clk(clk),
      .load_rst(do_rst), .rst_val(reset_code_val),
      .load_clr(clr_fall), .clr_val(clear_code_val),
      .wr(wr_i), .wr_val(frame_data),
      .xfer(xfer_i),
      .pd_wr(op.power & frame_data[i]), .pd_val(frame_data[9:8]),
      .live(dac_code[i*CODE_W +: CODE_W]),
      .pd(pd_mode[2*i +: 2]));
  end

  // Assertions
  a_r8_clear_loads: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fall |=> (dac_code == {CH{$past(clear_code_val)}}));

  a_r9_ldac_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (ldac_fall && !clr_lvl && !frame_valid) |=> $stable(dac_code));

  a_r10_pd_keeps_code: assert property (@(posedge clk) disable iff (!rst_n)
    (op.power && !ldac_fire) |=> $stable(dac_code));

  a_r11_sw_reset: assert property (@(posedge clk) disable iff (!rst_n)
    op.reset |=> (dac_code == {CH{$past(reset_code_val)}}) && (pd_mode == '0));

  a_r12_reserved_noop: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && frame_cmd[3] && !ldac_fall) |=> $stable(dac_code) && $stable(pd_mode));
endmodule

// File: tb/quad_dac_ctrl_tb.sv
module quad_dac_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_valid = 1'b0;
  logic [3:0]  frame_cmd = '0;
  logic [3:0]  frame_addr = '0;
  logic [15:0] frame_data = '0;
  logic        ldac_n = 1'b1;
  logic        clr_n = 1'b1;
  logic        por_mid = 1'b0;
  logic [63:0] dac_code;
  logic [7:0]  pd_mode;

  int    checks = 0;
  int    errors = 0;
  string phase = "R1";
  bit    started = 0;

  always #10 clk = ~clk;

  quad_dac_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_cmd(frame_cmd),
    .frame_addr(frame_addr), .frame_data(frame_data), .ldac_n(ldac_n), .clr_n(clr_n),
    .por_mid(por_mid), .dac_code(dac_code), .pd_mode(pd_mode));

  // Behavioural reference model
  logic [15:0] m_in [4];
  logic [15:0] m_out[4];
  logic [1:0]  m_pd [4];
  logic [3:0]  m_ovr;
  logic [1:0]  m_cc;
  bit l1, l2, lp, c1, c2, cp;

  function automatic logic [15:0] cc_code(input logic [1:0] s);
    if (s == 2'b00) return 16'h0000;
    if (s == 2'b01) return 16'h8000;
    return 16'hFFFF;
  endfunction

  always @(posedge clk) begin
    bit lf, cf, fok;
    bit [3:0] sel;
    started = 1;
    lf = lp && !l2;
    cf = cp && !c2;
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        m_in[i] = por_mid ? 16'h8000 : 16'h0000; m_out[i] = m_in[i]; m_pd[i] = 0;
      end
      m_ovr = 0; m_cc = 0;
      l1 = 1; l2 = 1; lp = 1; c1 = 1; c2 = 1; cp = 1;
    end else begin
      fok = frame_valid && !cf;
      for (int i = 0; i < 4; i++) sel[i] = (frame_addr == i) || (frame_addr == 4'hF);
      if (fok && frame_cmd == 4'h7) begin
        for (int i = 0; i < 4; i++) begin
          m_in[i] = por_mid ? 16'h8000 : 16'h0000; m_out[i] = m_in[i]; m_pd[i] = 0;
        end
        m_ovr = 0; m_cc = 0;
      end else if (cf) begin
        for (int i = 0; i < 4; i++) begin m_in[i] = cc_code(m_cc); m_out[i] = m_in[i]; end
      end else begin
        if (fok && !(frame_cmd <= 4'h3 && sel == 0)) begin
          case (frame_cmd)
            4'h0: for (int i = 0; i < 4; i++) if (sel[i]) begin
                    m_in[i] = frame_data;
                    if (!l2 || m_ovr[i]) m_out[i] = frame_data;
                  end
            4'h1: for (int i = 0; i < 4; i++) if (sel[i]) m_out[i] = m_in[i];
            4'h2: begin
                    for (int i = 0; i < 4; i++) if (sel[i]) m_in[i] = frame_data;
                    for (int i = 0; i < 4; i++) m_out[i] = m_in[i];
                  end
            4'h3: for (int i = 0; i < 4; i++) if (sel[i]) begin
                    m_in[i] = frame_data; m_out[i] = frame_data;
                  end
            4'h4: for (int i = 0; i < 4; i++) if (frame_data[i]) m_pd[i] = frame_data[9:8];
            4'h5: if (frame_data[1:0] != 2'b11) m_cc = frame_data[1:0];
            4'h6: m_ovr = frame_data[3:0];
            default: ;
          endcase
        end
        if (lf && c2) for (int i = 0; i < 4; i++) m_out[i] = m_in[i];
      end
      lp = l2; l2 = l1; l1 = ldac_n;
      cp = c2; c2 = c1; c1 = clr_n;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (started) begin
    chk({phase, " model code"}, dac_code, {m_out[3], m_out[2], m_out[1], m_out[0]});
    chk({phase, " model pd"}, {56'h0, pd_mode}, {56'h0, m_pd[3], m_pd[2], m_pd[1], m_pd[0]});
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [3:0] c, input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    frame_valid = 1; frame_cmd = c; frame_addr = a; frame_data = d;
    @(negedge clk);
    frame_valid = 0;
  endtask

  task automatic ldac_pulse();
    ldac_n = 0; idle(4); ldac_n = 1; idle(4);
  endtask

  // Drive a pin low, then present a frame in the cycle its edge is applied
  task automatic pin_and_frame(input bit is_clr, input logic [3:0] c,
                               input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    if (is_clr) clr_n = 0; else ldac_n = 0;
    @(negedge clk);
    @(negedge clk);
    frame_valid = 1; frame_cmd = c; frame_addr = a; frame_data = d;
    @(negedge clk);
    frame_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3); rst_n = 1; idle(2);
    phase = "R1"; chk("R1 reset zero scale", dac_code, 64'h0);
    chk("R1 reset pd", {56'h0, pd_mode}, 64'h0);

    phase = "R3"; ldac_n = 0; idle(4);
    send(4'h0, 4'h0, 16'h1234); idle(1);
    chk("R3 write with load low", {48'h0, dac_code[15:0]}, 64'h1234);
    ldac_n = 1; idle(4);
    send(4'h0, 4'h1, 16'h5555); idle(1);
    chk("R3 staged only", {48'h0, dac_code[31:16]}, 64'h0);

    phase = "R4"; ldac_n = 0; idle(4);
    chk("R4 load edge copies", {48'h0, dac_code[31:16]}, 64'h5555);
    ldac_n = 1; idle(4);

    phase = "R5";
    send(4'h0, 4'h2, 16'h7777); send(4'h1, 4'h2, 16'h0); idle(1);
    chk("R5 copy opcode", {48'h0, dac_code[47:32]}, 64'h7777);
    send(4'h3, 4'h3, 16'hABCD); idle(1);
    chk("R5 write-update opcode", {48'h0, dac_code[63:48]}, 64'hABCD);
    send(4'h0, 4'h1, 16'h2222); send(4'h2, 4'h0, 16'h1111); idle(1);
    chk("R5 write-all opcode", dac_code, 64'hABCD_7777_2222_1111);

    phase = "R2";
    send(4'h0, 4'hF, 16'h4444); idle(1);
    chk("R2 broadcast staged", dac_code, 64'hABCD_7777_2222_1111);
    ldac_pulse();
    chk("R2 broadcast after load", dac_code, 64'h4444_4444_4444_4444);
    send(4'h3, 4'h5, 16'h9999); idle(1);
    chk("R2 unmapped address", dac_code, 64'h4444_4444_4444_4444);

    phase = "R6";
    send(4'h6, 4'h0, 16'h0002); send(4'h0, 4'hF, 16'h6000); idle(1);
    chk("R6 override channel B", dac_code, 64'h4444_4444_6000_4444);

    phase = "R8";
    send(4'h5, 4'h0, 16'h0002);
    clr_n = 0; idle(4);
    chk("R8 clear full scale", dac_code, 64'hFFFF_FFFF_FFFF_FFFF);

    phase = "R9";
    send(4'h0, 4'h0, 16'h0100); idle(1);
    ldac_pulse();
    chk("R9 load ignored during clear", {48'h0, dac_code[15:0]}, 64'hFFFF);
    clr_n = 1; idle(4);
    ldac_pulse();
    chk("R9 load after clear release", {48'h0, dac_code[15:0]}, 64'h0100);

    phase = "R7";
    send(4'h5, 4'h0, 16'h0003);
    clr_n = 0; idle(4); clr_n = 1; idle(4);
    chk("R7 selector 11 ignored", dac_code, 64'hFFFF_FFFF_FFFF_FFFF);
    send(4'h5, 4'h0, 16'h0001);
    clr_n = 0; idle(4); clr_n = 1; idle(4);
    chk("R7 selector midscale", dac_code, 64'h8000_8000_8000_8000);

    phase = "R10";
    send(4'h4, 4'h0, 16'h0305); send(4'h4, 4'h0, 16'h0102); idle(1);
    chk("R10 power modes", {56'h0, pd_mode}, 64'h37);
    chk("R10 codes kept", dac_code, 64'h8000_8000_8000_8000);

    phase = "R12";
    send(4'h8, 4'hF, 16'h1234); send(4'hF, 4'h0, 16'h0F03); idle(1);
    chk("R12 reserved codes", dac_code, 64'h8000_8000_8000_8000);
    chk("R12 reserved pd", {56'h0, pd_mode}, 64'h37);

    phase = "R8";
    send(4'h5, 4'h0, 16'h0000);
    pin_and_frame(1, 4'h3, 4'h0, 16'h1357); idle(1);
    chk("R8 frame dropped by clear", dac_code, 64'h0);
    clr_n = 1; idle(4);

    phase = "R13";
    send(4'h0, 4'h2, 16'h2468);
    pin_and_frame(0, 4'h0, 4'h0, 16'h9753); idle(1);
    chk("R13 write before copy", dac_code, 64'h0000_2468_0000_9753);
    ldac_n = 1; idle(4);

    phase = "R11"; por_mid = 1;
    send(4'h7, 4'h0, 16'h0); idle(1);
    chk("R11 soft reset midscale", dac_code, 64'h8000_8000_8000_8000);
    chk("R11 soft reset pd", {56'h0, pd_mode}, 64'h0);
    send(4'h0, 4'h1, 16'h1111); idle(1);
    chk("R11 override cleared", {48'h0, dac_code[31:16]}, 64'h8000);

    phase = "R1";
    rst_n = 0; idle(3); rst_n = 1; idle(2);
    chk("R1 reset midscale", dac_code, 64'h8000_8000_8000_8000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule